// File: doc/BRIEF.md
# Debounced Pin Change Detector

This block watches a small group of general-purpose input pins and records, for each pin, that its level has changed. A change in either direction counts: high to low or low to high. Each pin first passes through a two-flop synchronizer. A slow sample-enable tick then samples the pin. A new level is accepted only when two consecutive ticks both see it. With a tick of about 38.4 kHz, a level has to hold for between one and two tick periods before it is accepted, roughly 26 to 52 microseconds. This rejects short glitches and contact bounce.

Each pin has a change flag. An accepted change sets that pin's flag while the detect-enable input is high. Software reads a status byte that gives the four accepted pin levels and the four change flags. A read strobe clears every flag. An interrupt request is raised while the interrupt mask bit is set and at least one flag is set. The confirmed levels start at the pins' own values during reset, so leaving reset never reports a change. The tick comes from outside the block.

Top module: `pin_cos_detect`

## Requirements
- R1: While reset is held, the confirmed levels take the synchronized pin values and all flags clear. After reset, `status_o` equals {pin levels, 4'b0000} and `irq_o` is 0.
- R2: A pin that rises and stays high must be seen on two consecutive ticks. Its confirmed level then becomes 1 and its flag (bit i of `status_o[3:0]` for pin i) sets. After the first of those ticks, nothing visible has changed yet.
- R3: A pin that falls is handled the same way as R2. Its confirmed level becomes 0 and its flag sets.
- R4: If a new level is seen on one tick but the pin has returned to the confirmed level by the next tick, no flag sets and the confirmed level does not change.
- R5: While `det_en_i` is 0, confirmed levels still follow the pins as in R2 and R3, but no flag sets.
- R6: `status_o` always shows {confirmed levels [7:4], change flags [3:0]}, with bit 4+i and bit i belonging to pin i. A one-cycle `rd_i` pulse clears all flags on the clock edge that ends that cycle.
- R7: A change confirmed on the same edge that ends a read stays set after the read.
- R8: `irq_o` is 1 exactly when `irq_mask_i` is 1 and at least one flag is set.
- R9: Without a tick, a pin change alters neither the confirmed levels nor the flags, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; while low, the confirmed levels load from the pins |
| pins_i | input | 4 | Asynchronous input pins |
| tick_i | input | 1 | One-cycle sample-enable pulse |
| det_en_i | input | 1 | Enables the setting of change flags |
| irq_mask_i | input | 1 | Allows flags to raise the interrupt |
| rd_i | input | 1 | Status read strobe; clears all flags |
| status_o | output | 8 | {confirmed levels, change flags} |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a change confirmed on the very edge where a read clears the flags. To get there, the bench counts the synchronizer latency and the first debounce tick. It then raises the second tick and the read strobe in the same cycle. Glitch rejection is also checked. A pin is moved away from its confirmed level for exactly one tick and restored before the next tick, so the pending state has to be discarded.

// File: rtl/pin_cos_detect.sv
module pin_cos_detect #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             tick_i,
  input  logic             det_en_i,
  input  logic             irq_mask_i,
  input  logic             rd_i,
  output logic [2*NPINS-1:0] status_o,
  output logic             irq_o
);

  logic [NPINS-1:0] meta_q, sync_q, level_q, pend_q, flag_q;
  logic [NPINS-1:0] differs, confirm;

  assign differs = sync_q ^ level_q;
  assign confirm = tick_i ? (differs & pend_q) : '0;

  always_ff @(posedge clk) begin
    meta_q <= pins_i;
    sync_q <= meta_q;
    if (!rst_n) begin
      meta_q  <= pins_i;
      sync_q  <= pins_i;
      level_q <= pins_i;
      pend_q  <= '0;
      flag_q  <= '0;
    end else begin
      if (tick_i) pend_q <= differs & ~pend_q;
      level_q <= level_q ^ confirm;
      flag_q  <= (rd_i ? '0 : flag_q) | (det_en_i ? confirm : '0);
    end
  end

  assign status_o = {level_q, flag_q};
  assign irq_o    = irq_mask_i & (|flag_q);

endmodule

module pin_cos_detect_chk #(
  parameter int NPINS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               det_en_i,
  input logic               irq_mask_i,
  input logic               rd_i,
  input logic [2*NPINS-1:0] status_o,
  input logic               irq_o
);

  p_irq_follows_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_mask_i && (status_o[NPINS-1:0] != '0)));

  p_no_flag_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_i) && !$past(rd_i)) |-> status_o[NPINS-1:0] == $past(status_o[NPINS-1:0]));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_i) && !$past(tick_i)) |-> status_o[NPINS-1:0] == '0);

  p_disabled_no_new_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(det_en_i) |-> (status_o[NPINS-1:0] & ~$past(status_o[NPINS-1:0])) == '0);

endmodule

bind pin_cos_detect pin_cos_detect_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .det_en_i(det_en_i),
  .irq_mask_i(irq_mask_i), .rd_i(rd_i), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/pin_cos_detect_tb.sv
module pin_cos_detect_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, en = 1, mask = 1, rd = 0;
  logic [3:0] pins = 4'b0101;
  logic [7:0] status;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_cos_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .tick_i(tick), .det_en_i(en),
    .irq_mask_i(mask), .rd_i(rd), .status_o(status), .irq_o(irq)
  );

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask
  task automatic pulse_tick(); @(negedge clk) tick = 1; @(negedge clk) tick = 0; endtask
  task automatic do_read(logic [7:0] exp, string req);
    @(negedge clk) rd = 1;
    #1 chk8(req, status, exp);
    @(negedge clk) rd = 0;
    chk8({req, " clear R6"}, status, {exp[7:4], 4'b0000});
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk8("R1 status", status, 8'b0101_0000);
    chk8("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_no_tick();
    pins = 4'b0100;
    repeat (20) @(negedge clk);
    chk8("R9 no tick", status, 8'b0101_0000);
  endtask

  task automatic t_fall();
    pulse_tick();
    chk8("R3 first tick", status, 8'b0101_0000);
    pulse_tick();
    chk8("R3 fall", status, 8'b0100_0001);
    chk8("R8 irq set", {7'b0, irq}, 8'h01);
    do_read(8'b0100_0001, "R6 read");
    chk8("R8 irq clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    pins = 4'b0110; settle();
    pulse_tick();
    chk8("R2 first tick", status, 8'b0100_0000);
    pulse_tick();
    chk8("R2 rise", status, 8'b0110_0010);
    do_read(8'b0110_0010, "R6 read2");
  endtask

  task automatic t_mask();
    pins = 4'b1110; settle();
    pulse_tick(); pulse_tick();
    @(negedge clk) mask = 0;
    #1 chk8("R8 masked", {7'b0, irq}, 8'h00);
    @(negedge clk) mask = 1;
    #1 chk8("R8 unmasked", {7'b0, irq}, 8'h01);
    do_read(8'b1110_1000, "R6 read3");
  endtask

  task automatic t_glitch();
    pins = 4'b1010; settle();
    pulse_tick();
    pins = 4'b1110; settle();
    pulse_tick(); pulse_tick();
    chk8("R4 glitch", status, 8'b1110_0000);
  endtask

  task automatic t_disabled();
    en = 0; pins = 4'b1111; settle();
    pulse_tick(); pulse_tick();
    chk8("R5 disabled", status, 8'b1111_0000);
    en = 1;
  endtask

  task automatic t_read_race();
    pins = 4'b1110; settle();
    pulse_tick();
    @(negedge clk) begin tick = 1; rd = 1; end
    @(negedge clk) begin tick = 0; rd = 0; end
    chk8("R7 race", status, 8'b1110_0001);
  endtask

  initial begin
    t_reset(); t_no_tick(); t_fall(); t_rise(); t_mask();
    t_glitch(); t_disabled(); t_read_race();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; fails++; $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule